// File: doc/BRIEF.md
# External Bus Request/Grant Handshake

This block lends the external memory bus to an outside master and takes it back afterwards. The outside master asks for the bus by pulling an asynchronous active-low request line. The block samples that line into the core clock domain and waits for any memory access already under way to finish. It then turns off the output drivers of every memory select and of the read and write strobes. Only in the following cycle does it pull the active-low grant output.

When the master lets go of the request, the block first raises grant. One cycle later it turns the select and strobe drivers back on. While the bus is lent out, a separate active-low "grant hung" output tells the outside master that the core, or its DMA engine, needs the bus back. The block holds one of four states (owned, releasing, granted, reclaiming) in a one-hot register. The owned bit alone drives every output enable.

Top module: `bus_handoff`

## Requirements
- R1: In reset and just after reset, grant_n is 1, hung_n is 1, and every bit of sel_oe and strb_oe is 1, so the core drives the bus.
- R2: breq_n passes through two sampling flops. Suppose breq_n is low before a rising edge and stays low, with acc_busy low. The enables drop after the third rising edge, and grant_n goes low after the fourth.
- R3: grant_n is never 0 while any bit of sel_oe or strb_oe is 1. Every enable is 0 for at least one full cycle before grant_n falls.
- R4: While the bus is owned and acc_busy is 1, a sampled request does not release the bus. The enables stay 1 until the first cycle in which acc_busy is seen low.
- R5: Suppose breq_n goes high and stays high while the bus is granted. grant_n returns to 1 after the third rising edge, and the enables return to 1 one cycle later.
- R6: hung_n is 0 exactly when grant_n is 0 and core_need is 1, and is 1 otherwise.
- R7: A request seen for only one sampled cycle never drives grant_n low. The enables come back after the one releasing cycle.
- R8: All sel_oe bits and strb_oe bits always carry the same value. strb_oe bit 0 enables the read strobe and bit 1 the write strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| breq_n | input | 1 | Asynchronous active-low bus request from the outside master |
| acc_busy | input | 1 | A core memory access is in flight |
| core_need | input | 1 | Core or DMA needs the bus to continue |
| grant_n | output | 1 | Active-low bus grant |
| hung_n | output | 1 | Active-low grant-hung indication |
| sel_oe | output | NSEL | Output enables for the memory select lines |
| strb_oe | output | NSTRB | Output enables for the read (bit 0) and write (bit 1) strobes |

## Verification
Two functions can act in the same cycle. One is the withdrawal of grant when the request is dropped. The other is the grant-hung indication driven by core_need. The bench drives core_need high across the whole release and checks that hung_n rises in the same cycle that grant_n rises, with no cycle in which the two disagree. A second overlap is a request that becomes visible in the very cycle an in-flight access ends. Random runs of acc_busy against long and short request pulses provoke it, and a per-cycle expected model judges the result.

// File: rtl/bus_handoff.sv
module bus_handoff #(
  parameter int NSEL  = 5,
  parameter int NSTRB = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             breq_n,
  input  logic             acc_busy,
  input  logic             core_need,
  output logic             grant_n,
  output logic             hung_n,
  output logic [NSEL-1:0]  sel_oe,
  output logic [NSTRB-1:0] strb_oe
);
  localparam int S_OWN = 0;
  localparam int S_REL = 1;
  localparam int S_GNT = 2;
  localparam int S_RCL = 3;
  localparam int NST   = 4;

  logic [1:0]     sync_q;
  logic [NST-1:0] st_q, st_d;
  logic           req;

  assign req = sync_q[1];

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], ~breq_n};
  end

  always_comb begin
    st_d = '0;
    case (1'b1)
      st_q[S_OWN]: if (req && !acc_busy) st_d[S_REL] = 1'b1;
                   else                  st_d[S_OWN] = 1'b1;
      st_q[S_REL]: if (req) st_d[S_GNT] = 1'b1;
                   else     st_d[S_OWN] = 1'b1;
      st_q[S_GNT]: if (req) st_d[S_GNT] = 1'b1;
                   else     st_d[S_RCL] = 1'b1;
      st_q[S_RCL]: st_d[S_OWN] = 1'b1;
      default:     st_d[S_OWN] = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= NST'(1) << S_OWN;
    else        st_q <= st_d;
  end

  assign grant_n = ~st_q[S_GNT];
  assign hung_n  = ~(st_q[S_GNT] & core_need);
  assign sel_oe  = {NSEL{st_q[S_OWN]}};
  assign strb_oe = {NSTRB{st_q[S_OWN]}};
endmodule

// File: rtl/bus_handoff_chk.sv
module bus_handoff_chk #(
  parameter int NSEL  = 5,
  parameter int NSTRB = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc_busy,
  input logic             core_need,
  input logic             grant_n,
  input logic             hung_n,
  input logic [NSEL-1:0]  sel_oe,
  input logic [NSTRB-1:0] strb_oe
);
  a_r3_no_grant_while_driven: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_n |-> (sel_oe == '0 && strb_oe == '0));

  a_r3_quiet_before_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(grant_n) |-> ($past(sel_oe) == '0 && $past(strb_oe) == '0));

  a_r5_grant_up_before_drive: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_oe[0]) |-> (grant_n && $past(grant_n)));

  a_r4_busy_keeps_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_oe[0] && acc_busy) |=> sel_oe[0]);

  a_r6_hung_tracks_need: assert property (@(posedge clk) disable iff (!rst_n)
    (hung_n == !(!grant_n && core_need)));

  a_r8_uniform_enables: assert property (@(posedge clk) disable iff (!rst_n)
    ((sel_oe == '0 || sel_oe == '1) && strb_oe == {NSTRB{sel_oe[0]}}));
endmodule

bind bus_handoff bus_handoff_chk #(.NSEL(NSEL), .NSTRB(NSTRB)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_busy(acc_busy), .core_need(core_need),
  .grant_n(grant_n), .hung_n(hung_n), .sel_oe(sel_oe), .strb_oe(strb_oe)
);

// File: tb/bus_handoff_test.sv
module bus_handoff_test;
  localparam int NSEL  = 5;
  localparam int NSTRB = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic breq_n = 1'b1, acc_busy = 1'b0, core_need = 1'b0;
  logic grant_n, hung_n;
  logic [NSEL-1:0]  sel_oe;
  logic [NSTRB-1:0] strb_oe;

  int n_run = 0, n_fail = 0;
  bit m_s1, m_s2;
  int m_st;

  always #10 clk = ~clk;

  bus_handoff #(.NSEL(NSEL), .NSTRB(NSTRB)) uut (
    .clk(clk), .rst_n(rst_n), .breq_n(breq_n), .acc_busy(acc_busy),
    .core_need(core_need), .grant_n(grant_n), .hung_n(hung_n),
    .sel_oe(sel_oe), .strb_oe(strb_oe)
  );

  function automatic bit exp_grant_n(int st);       return st != 2; endfunction
  function automatic bit exp_en(int st);            return st == 0; endfunction
  function automatic bit exp_hung_n(int st, bit n); return !(st == 2 && n); endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cmp_model();
    bit e = exp_en(m_st);
    check("R2 grant_n vs model", 32'(grant_n), 32'(exp_grant_n(m_st)));
    check("R8 sel_oe vs model", 32'(sel_oe), e ? 32'((1 << NSEL) - 1) : 0);
    check("R8 strb_oe vs model", 32'(strb_oe), e ? 32'((1 << NSTRB) - 1) : 0);
    check("R6 hung_n vs model", 32'(hung_n), 32'(exp_hung_n(m_st, core_need)));
    if (!grant_n) check("R3 enables off under grant", 32'({sel_oe, strb_oe}), 0);
  endtask

  task automatic step(bit rq_n, bit busy, bit need);
    int nx;
    breq_n = rq_n; acc_busy = busy; core_need = need;
    @(posedge clk);
    nx = m_st;
    case (m_st)
      0: if (m_s2 && !busy) nx = 1;
      1: nx = m_s2 ? 2 : 0;
      2: if (!m_s2) nx = 3;
      default: nx = 0;
    endcase
    m_st = nx; m_s2 = m_s1; m_s1 = !rq_n;
    @(negedge clk);
    cmp_model();
  endtask

  initial begin
    #4_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    m_s1 = 0; m_s2 = 0; m_st = 0;
    repeat (3) @(negedge clk);
    check("R1 reset grant_n", 32'(grant_n), 1);
    check("R1 reset hung_n", 32'(hung_n), 1);
    check("R1 reset enables", 32'({sel_oe, strb_oe}), 32'((1 << (NSEL + NSTRB)) - 1));
    rst_n = 1'b1;
    step(1, 0, 0);
    check("R1 after reset enables", 32'(sel_oe[0]), 1);

    step(0, 0, 0); step(0, 0, 0);
    check("R2 enables still on after two edges", 32'(sel_oe[0]), 1);
    step(0, 0, 0);
    check("R3 enables off, grant still high", 32'({grant_n, sel_oe[0], strb_oe[1]}), 32'b100);
    step(0, 0, 0);
    check("R2 grant low at fourth edge", 32'(grant_n), 0);
    step(0, 0, 1);
    check("R6 hung asserted", 32'(hung_n), 0);

    step(1, 0, 1); step(1, 0, 1);
    check("R5 grant held two edges after withdrawal", 32'(grant_n), 0);
    step(1, 0, 1);
    check("R5 grant high at third edge", 32'({grant_n, sel_oe[0]}), 32'b10);
    check("R6 hung drops with grant", 32'(hung_n), 1);
    step(1, 0, 0);
    check("R5 enables back one cycle later", 32'(sel_oe[0]), 1);

    for (int i = 0; i < 8; i++) step(0, 1, 0);
    check("R4 busy keeps bus", 32'({grant_n, sel_oe[0]}), 32'b11);
    step(0, 0, 0);
    check("R4 release after busy ends", 32'(sel_oe[0]), 0);
    step(0, 0, 0);
    check("R4 grant follows", 32'(grant_n), 0);
    for (int i = 0; i < 5; i++) step(1, 0, 0);

    step(0, 0, 0); step(1, 0, 0); step(1, 0, 0);
    check("R7 short pulse releasing", 32'({grant_n, sel_oe[0]}), 32'b10);
    step(1, 0, 0);
    check("R7 short pulse never grants", 32'({grant_n, sel_oe[0]}), 32'b11);

    for (int i = 0; i < 400; i++) begin
      bit rq = $urandom_range(0, 1) == 1;
      int len = $urandom_range(1, 10);
      for (int k = 0; k < len; k++)
        step(!rq, $urandom_range(0, 3) == 0, $urandom_range(0, 1) == 1);
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule